// File: doc/BRIEF.md
# BCD Digit Mini Calculator

A purely combinational calculator core for single decimal digits. Two 4-bit operands, each expected to lie between 0 and 9, are combined according to a 2-bit operation code. The block can add them, subtract the second from the first, or multiply them. It can also be switched off.

The block first builds the result as an unsigned magnitude with a separate negative flag. It then splits that magnitude into a tens digit and a units digit with a shift-and-add-3 converter. The converter is trimmed for results no larger than 81. Every digit is decoded to a 7-segment pattern. The operand digits drive their own displays. A minus-sign display and three operator flags drive a separate indicator.

The block has no clock and no storage. It sits between the digit switches and the display drivers.

Top module: `bcd_calc_core`

## Requirements
- R1: With op_i = 2'b00 (off), seg_tens_o, seg_units_o, seg_sign_o and all three operator flags are zero.
- R2: With op_i = 2'b01 and both operands at most 9, the tens and units displays show a_i + b_i.
- R3: With op_i = 2'b10 and both operands at most 9, the displays show the magnitude of a_i - b_i. seg_sign_o equals 7'h40 (segment g only) exactly when a_i < b_i.
- R4: With op_i = 2'b11 and both operands at most 9, the displays show a_i * b_i.
- R5: seg_sign_o is nonzero only while op_i = 2'b10.
- R6: Segment vectors are active-high, with bit 0 = a through bit 6 = g. Digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R7: seg_a_o and seg_b_o show their operand in every mode. An operand above 9 gives an all-zero pattern on its own display.
- R8: seg_tens_o is zero when the result is below 10. seg_units_o shows the digit 0 for a zero result.
- R9: If either operand is above 9, seg_tens_o, seg_units_o and seg_sign_o are zero in every mode, while the operator flags still follow op_i.
- R10: op_add_o, op_sub_o and op_mul_o are set for codes 01, 10 and 11 respectively. At most one is set, and none is set for code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | First operand digit |
| b_i | input | 4 | Second operand digit |
| op_i | input | 2 | Operation: 00 off, 01 add, 10 subtract, 11 multiply |
| seg_a_o | output | 7 | Segments for operand a |
| seg_b_o | output | 7 | Segments for operand b |
| seg_sign_o | output | 7 | Minus-sign display (only g used) |
| seg_tens_o | output | 7 | Segments for result tens digit |
| seg_units_o | output | 7 | Segments for result units digit |
| op_add_o | output | 1 | Addition selected |
| op_sub_o | output | 1 | Subtraction selected |
| op_mul_o | output | 1 | Multiplication selected |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle as its stimulus, with zero register delay. The bench changes the inputs on the falling clock edge and samples all outputs 2 ns later, well before the next rising edge, so every sample sees settled values for exactly one stimulus. All 100 valid operand pairs are swept in each of the four modes. Seeded random vectors that include codes 10 to 15 follow, along with directed pattern checks.

// File: rtl/calc_pkg.sv
package calc_pkg;
  localparam int DIG_W = 4;
  localparam int SEG_W = 7;
  localparam int RES_W = 2 * DIG_W;
  localparam int MAX_DIGIT = 9;

  typedef enum logic [1:0] {
    OP_OFF = 2'b00,
    OP_ADD = 2'b01,
    OP_SUB = 2'b10,
    OP_MUL = 2'b11
  } op_e;

  localparam logic [SEG_W-1:0] SEG_MINUS = 7'h40;
endpackage

// File: rtl/calc_addsub.sv
module calc_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W:0]   mag_o,
  output logic         neg_o
);
  logic [W:0]   x, y, s, inv;
  logic [W+1:0] c;
  logic [W+1:0] h;

  assign x    = {1'b0, a_i};
  assign y    = {1'b0, b_i} ^ {(W+1){sub_i}};
  assign c[0] = sub_i;

  // full-adder chain
  for (genvar i = 0; i <= W; i++) begin : g_fa
    assign s[i]   = x[i] ^ y[i] ^ c[i];
    assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
  end

  assign neg_o = sub_i & s[W];
  assign inv   = s ^ {(W+1){neg_o}};
  assign h[0]  = neg_o;

  // complement-and-increment to magnitude
  for (genvar i = 0; i <= W; i++) begin : g_inc
    assign mag_o[i] = inv[i] ^ h[i];
    assign h[i+1]   = inv[i] & h[i];
  end

  always_comb begin
    if (sub_i && a_i <= 4'd9 && b_i <= 4'd9) begin
      a_r3_neg_iff_less: assert (neg_o == (a_i < b_i));
      a_r3_magnitude: assert (int'(mag_o) ==
        ((a_i >= b_i) ? int'(a_i) - int'(b_i) : int'(b_i) - int'(a_i)));
    end
  end
endmodule

// File: rtl/calc_mul.sv
module calc_mul #(
  parameter int W = 4
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  localparam int PW = 2 * W;
  logic [PW-1:0] acc [W+1];

  assign acc[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [W-1:0]  pp;
    logic [PW-1:0] pp_sh;
    assign pp     = a_i & {W{b_i[i]}};
    assign pp_sh  = PW'(pp) << i;
    assign acc[i+1] = acc[i] + pp_sh;
  end

  assign prod_o = acc[W];

  always_comb begin
    if (a_i <= 4'd9 && b_i <= 4'd9) begin
      a_r4_product_range: assert (prod_o <= PW'(81));
    end
  end
endmodule

// File: rtl/calc_bin2bcd.sv
module calc_bin2bcd #(
  parameter int BIN_W = 8
) (
  input  logic [BIN_W-1:0] bin_i,
  output logic [3:0]       tens_o,
  output logic [3:0]       units_o
);
  // Input bounded to 81: tens never reaches 5 before its last shift,
  // so only the units column carries add-3 cells and no hundreds digit.
  always_comb begin
    logic [3:0] t, u;
    t = '0;
    u = '0;
    for (int i = BIN_W - 1; i >= 0; i--) begin
      if (u >= 4'd5) u = u + 4'd3;
      {t, u} = {t[2:0], u, bin_i[i]};
    end
    tens_o  = t;
    units_o = u;
  end

  always_comb begin
    if (bin_i <= BIN_W'(81)) begin
      a_r8_bcd_value: assert (int'(tens_o) * 10 + int'(units_o) == int'(bin_i));
      a_r8_units_digit: assert (units_o <= 4'd9);
    end
  end
endmodule

// File: rtl/calc_seg7.sv
module calc_seg7 (
  input  logic [3:0] digit_i,
  input  logic       en_i,
  output logic [6:0] seg_o
);
  logic [6:0] pat;

  // bit0 = a ... bit6 = g, active high
  always_comb begin
    unique case (digit_i)
      4'd0:    pat = 7'h3F;
      4'd1:    pat = 7'h06;
      4'd2:    pat = 7'h5B;
      4'd3:    pat = 7'h4F;
      4'd4:    pat = 7'h66;
      4'd5:    pat = 7'h6D;
      4'd6:    pat = 7'h7D;
      4'd7:    pat = 7'h07;
      4'd8:    pat = 7'h7F;
      4'd9:    pat = 7'h6F;
      default: pat = 7'h00;
    endcase
  end

  assign seg_o = en_i ? pat : 7'h00;

  always_comb begin
    a_r6_blank_when_off: assert (en_i || seg_o == 7'h00);
  end
endmodule

// File: rtl/bcd_calc_core.sv
module bcd_calc_core
  import calc_pkg::*;
(
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic [1:0] op_i,
  output logic [6:0] seg_a_o,
  output logic [6:0] seg_b_o,
  output logic [6:0] seg_sign_o,
  output logic [6:0] seg_tens_o,
  output logic [6:0] seg_units_o,
  output logic       op_add_o,
  output logic       op_sub_o,
  output logic       op_mul_o
);
  localparam int NDISP = 4;

  op_e              op;
  logic             a_ok, b_ok, res_on;
  logic [DIG_W:0]   as_mag;
  logic             as_neg;
  logic [RES_W-1:0] prod, res_bin;
  logic [3:0]       tens, units;
  logic [3:0]       disp_dig [NDISP];
  logic             disp_en  [NDISP];
  logic [SEG_W-1:0] disp_seg [NDISP];

  assign op     = op_e'(op_i);
  assign a_ok   = a_i <= DIG_W'(MAX_DIGIT);
  assign b_ok   = b_i <= DIG_W'(MAX_DIGIT);
  assign res_on = a_ok && b_ok && (op != OP_OFF);

  assign op_add_o = (op == OP_ADD);
  assign op_sub_o = (op == OP_SUB);
  assign op_mul_o = (op == OP_MUL);

  calc_addsub #(.W(DIG_W)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (op == OP_SUB),
    .mag_o (as_mag),
    .neg_o (as_neg)
  );

  calc_mul #(.W(DIG_W)) u_mul (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod)
  );

  // pass only the selected operation
  assign res_bin = (op == OP_MUL) ? prod : RES_W'(as_mag);

  calc_bin2bcd #(.BIN_W(RES_W)) u_bcd (
    .bin_i   (res_bin),
    .tens_o  (tens),
    .units_o (units)
  );

  assign disp_dig[0] = a_i;
  assign disp_dig[1] = b_i;
  assign disp_dig[2] = tens;
  assign disp_dig[3] = units;
  assign disp_en[0]  = 1'b1;
  assign disp_en[1]  = 1'b1;
  assign disp_en[2]  = res_on && (tens != 4'd0);
  assign disp_en[3]  = res_on;

  for (genvar d = 0; d < NDISP; d++) begin : g_disp
    calc_seg7 u_seg (
      .digit_i (disp_dig[d]),
      .en_i    (disp_en[d]),
      .seg_o   (disp_seg[d])
    );
  end

  assign seg_a_o     = disp_seg[0];
  assign seg_b_o     = disp_seg[1];
  assign seg_tens_o  = disp_seg[2];
  assign seg_units_o = disp_seg[3];
  assign seg_sign_o  = (res_on && as_neg) ? SEG_MINUS : '0;

  always_comb begin
    a_r10_flags_onehot0: assert ($onehot0({op_add_o, op_sub_o, op_mul_o}));
    if (seg_sign_o != '0) begin
      a_r5_sign_sub_only: assert (op_i == 2'b10);
    end
    if (op_i == 2'b00) begin
      a_r1_off_blank: assert (seg_tens_o == '0 && seg_units_o == '0 &&
                              seg_sign_o == '0 && !op_add_o && !op_sub_o && !op_mul_o);
    end
    if (!a_ok || !b_ok) begin
      a_r9_invalid_blank: assert (seg_tens_o == '0 && seg_units_o == '0 && seg_sign_o == '0);
    end
  end
endmodule

// File: tb/bcd_calc_core_tb.sv
module bcd_calc_core_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] a, b;
  logic [1:0] op;
  logic [6:0] seg_a, seg_b, seg_sign, seg_tens, seg_units;
  logic       f_add, f_sub, f_mul;

  int n_chk = 0;
  int n_bad = 0;

  bcd_calc_core u_dut (
    .a_i(a), .b_i(b), .op_i(op),
    .seg_a_o(seg_a), .seg_b_o(seg_b), .seg_sign_o(seg_sign),
    .seg_tens_o(seg_tens), .seg_units_o(seg_units),
    .op_add_o(f_add), .op_sub_o(f_sub), .op_mul_o(f_mul)
  );

  function automatic logic [6:0] ref_seg(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s a=%0d b=%0d op=%0d: got %h expected %h", tag, what, a, b, op, got, exp);
    end
  endtask

  task automatic apply(int va, int vb, int vop);
    bit   valid, neg;
    int   r;
    string rtag;
    @(negedge clk);
    a  = 4'(va);
    b  = 4'(vb);
    op = 2'(vop);
    #2;
    valid = (va <= 9) && (vb <= 9) && (vop != 0);
    case (vop)
      1: r = va + vb;
      2: r = (va >= vb) ? va - vb : vb - va;
      3: r = va * vb;
      default: r = 0;
    endcase
    neg = (vop == 2) && (va < vb);
    if (vop == 0) rtag = "R1";
    else if (!valid) rtag = "R9";
    else if (vop == 1) rtag = "R2";
    else if (vop == 2) rtag = "R3";
    else rtag = "R4";
    chk(rtag, "units", seg_units, valid ? ref_seg(r % 10) : 0);
    chk((valid && r < 10) ? "R8" : rtag, "tens", seg_tens,
        (valid && r >= 10) ? ref_seg(r / 10) : 0);
    chk((vop == 2) ? "R3" : "R5", "sign", seg_sign, (valid && neg) ? 7'h40 : 0);
    chk("R7", "seg_a", seg_a, ref_seg(va));
    chk("R7", "seg_b", seg_b, ref_seg(vb));
    chk("R10", "flags", {f_add, f_sub, f_mul},
        {vop == 1, vop == 2, vop == 3});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    a = '0; b = '0; op = '0;
    seed = $urandom(32'd2024);
    // R1 reset-like idle state
    #2;
    chk("R1", "idle units", seg_units, 0);
    chk("R1", "idle flags", {f_add, f_sub, f_mul}, 0);
    // R2 R3 R4 R1 exhaustive sweep
    for (int o = 0; o < 4; o++)
      for (int x = 0; x < 10; x++)
        for (int y = 0; y < 10; y++)
          apply(x, y, o);
    // R6 directed patterns
    apply(8, 1, 0);
    chk("R6", "digit8", seg_a, 7'h7F);
    chk("R6", "digit1", seg_b, 7'h06);
    // R8 zero result shows 0, tens blank
    apply(5, 5, 2);
    chk("R8", "zero units", seg_units, 7'h3F);
    chk("R8", "zero tens", seg_tens, 7'h00);
    // R3 R4 extremes
    apply(0, 9, 2);
    apply(9, 9, 3);
    apply(9, 9, 1);
    // R9 invalid operands
    apply(10, 3, 1);
    apply(3, 15, 3);
    apply(12, 12, 2);
    // random mix including invalid codes
    for (int k = 0; k < 300; k++)
      apply(int'($urandom() % 16), int'($urandom() % 16), int'($urandom() % 4));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule